// File: doc/BRIEF.md
# SIMT Branch Divergence Mask Controller

This block follows the active-lane mask of a single warp whose lanes all execute the same instruction in the same cycle. Each cycle the issue logic may present a conditional branch. The branch carries one predicate bit per lane, a target PC and the PC where the two sides meet again. The predicate is looked at only on lanes that are currently active.

When every active lane agrees, the warp moves to the target PC or to the next PC with its mask unchanged. When they disagree, the controller pushes an entry onto an internal divergence stack. The lanes that take the branch run first and the others are masked off. A later path-done strobe switches the warp to the waiting lanes at the fall-through PC. A second path-done strobe restores the pre-branch mask at the meeting PC and pops the entry.

Masked lanes still use the issue slot. The controller therefore reports the number of active lanes every cycle, which lets the surrounding logic measure lane utilization. Divergence can nest up to the stack depth. A divergent branch that arrives with the stack full sets a sticky error flag and pushes nothing.

Top module: `simt_diverge_ctrl`

## Requirements
- R1: After reset, `cur_pc` equals the RESET_PC parameter, `act_mask` has all LANES bits set, `active_cnt` equals LANES and `ovf_err` is 0.
- R2: A branch whose predicate is 1 on every active lane moves `cur_pc` to `br_target` on the next cycle. A branch whose predicate is 0 on every active lane moves `cur_pc` to `cur_pc`+1. In both cases `act_mask` is unchanged.
- R3: A divergent branch (predicate 1 on some active lanes and 0 on others) with the stack not full sets `act_mask` to the active lanes whose predicate is 1 and sets `cur_pc` to `br_target` on the next cycle. It also pushes one stack entry.
- R4: A `path_done` strobe while the top stack entry still has a waiting path sets `act_mask` to the lanes that were active at the branch and had predicate 0. It sets `cur_pc` to the branch PC plus 1, and the entry stays on the stack.
- R5: A `path_done` strobe while the top entry has no waiting path restores `act_mask` to the mask held before that branch, sets `cur_pc` to the entry's reconvergence PC and pops the entry.
- R6: Divergent branches nest up to DEPTH levels, and the entries unwind in reverse order of their pushes. The active mask is never all-zero.
- R7: A divergent branch that arrives with DEPTH entries held sets `ovf_err`, which stays at 1 until reset. It leaves `cur_pc`, `act_mask` and the stack contents unchanged.
- R8: `active_cnt` always equals the number of set bits in `act_mask`.
- R9: `path_done` with an empty stack has no effect. When `path_done` and `br_valid` are both high in one cycle, `path_done` is acted on and the branch is ignored.
- R10: Predicate bits on inactive lanes have no effect on the branch outcome.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| br_valid | input | 1 | Branch presented this cycle |
| br_pred | input | LANES | Per-lane branch predicate, 1 = taken |
| br_target | input | PC_W | Taken-path PC |
| br_reconv | input | PC_W | Reconvergence PC of the branch |
| path_done | input | 1 | Running path has reached the reconvergence PC |
| cur_pc | output | PC_W | PC of the path now issuing |
| act_mask | output | LANES | Lanes enabled for the current issue slot |
| active_cnt | output | $clog2(LANES+1) | Number of enabled lanes |
| ovf_err | output | 1 | Sticky divergence-stack overflow flag |

## Verification
The hardest state to reach from the ports is a full stack that receives one more divergent branch. Reaching it needs DEPTH nested branches, and each branch must split the mask left by the one before. The directed part of the bench halves the active lanes at each level until the stack is full, then sends one more split. It then unwinds every level and checks that the overflowing branch left nothing behind. Random traffic afterwards mixes branches, strobes and same-cycle collisions, and a bench-side model of the stack checks every result.

// File: rtl/simt_div_pkg.sv
package simt_div_pkg;

   typedef enum logic [1:0] {
      BR_UNI_NOT = 2'd0,
      BR_UNI_TKN = 2'd1,
      BR_SPLIT   = 2'd2
   } br_kind_e;

   // Classify a branch from whether any active lane goes each way.
   function automatic br_kind_e classify(input logic any_tkn, input logic any_not);
      if (any_tkn && any_not) return BR_SPLIT;
      if (any_tkn)            return BR_UNI_TKN;
      return BR_UNI_NOT;
   endfunction

endpackage

// File: rtl/simt_popcount.sv
module simt_popcount #(
   parameter int unsigned WIDTH = 32,
   localparam int unsigned CNT_W = $clog2(WIDTH + 1)
) (
   input  logic [WIDTH-1:0] vec,
   output logic [CNT_W-1:0] cnt
);

   generate
      if (WIDTH < 2) begin : g_bad_width
         $error("simt_popcount: WIDTH must be at least 2");
      end
   endgenerate

   always_comb begin
      cnt = '0;
      for (int i = 0; i < int'(WIDTH); i++) begin
         cnt = cnt + CNT_W'(vec[i]);
      end
   end

endmodule

// File: rtl/simt_mask_stack.sv
module simt_mask_stack #(
   parameter int unsigned LANES = 32,
   parameter int unsigned PC_W  = 16,
   parameter int unsigned DEPTH = 4,
   localparam int unsigned SP_W  = $clog2(DEPTH + 1),
   localparam int unsigned IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             push,
   input  logic [PC_W-1:0]  push_rc,
   input  logic [LANES-1:0] push_saved,
   input  logic [LANES-1:0] push_pmask,
   input  logic [PC_W-1:0]  push_ppc,
   input  logic             pop,
   input  logic             clr_pend,
   output logic             empty,
   output logic             full,
   output logic [PC_W-1:0]  top_rc,
   output logic [LANES-1:0] top_saved,
   output logic [LANES-1:0] top_pmask,
   output logic [PC_W-1:0]  top_ppc,
   output logic             top_pv
);

   generate
      if (DEPTH < 2) begin : g_bad_depth
         $error("simt_mask_stack: DEPTH must be at least 2");
      end
   endgenerate

   logic [PC_W-1:0]  rc_q    [DEPTH];
   logic [LANES-1:0] saved_q [DEPTH];
   logic [LANES-1:0] pmask_q [DEPTH];
   logic [PC_W-1:0]  ppc_q   [DEPTH];
   logic [DEPTH-1:0] pv_q;
   logic [SP_W-1:0]  sp_q;
   logic [IDX_W-1:0] top_ix;
   logic [IDX_W-1:0] wr_ix;

   assign empty  = (sp_q == '0);
   assign full   = (sp_q == SP_W'(DEPTH));
   assign top_ix = empty ? '0 : IDX_W'(sp_q - SP_W'(1));
   assign wr_ix  = full ? '0 : IDX_W'(sp_q);

   assign top_rc    = rc_q[top_ix];
   assign top_saved = saved_q[top_ix];
   assign top_pmask = pmask_q[top_ix];
   assign top_ppc   = ppc_q[top_ix];
   assign top_pv    = pv_q[top_ix];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sp_q <= '0;
         pv_q <= '0;
         for (int i = 0; i < int'(DEPTH); i++) begin
            rc_q[i]    <= '0;
            saved_q[i] <= '0;
            pmask_q[i] <= '0;
            ppc_q[i]   <= '0;
         end
      end else if (push) begin
         rc_q[wr_ix]    <= push_rc;
         saved_q[wr_ix] <= push_saved;
         pmask_q[wr_ix] <= push_pmask;
         ppc_q[wr_ix]   <= push_ppc;
         pv_q[wr_ix]    <= 1'b1;
         sp_q           <= sp_q + SP_W'(1);
      end else if (clr_pend) begin
         pv_q[top_ix] <= 1'b0;
      end else if (pop) begin
         sp_q <= sp_q - SP_W'(1);
      end
   end

   // R7: the controller must never push into a full stack
   assert_no_push_full_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !(push && full));

   // R9: nothing is taken from an empty stack
   assert_no_pop_empty_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !((pop || clr_pend) && empty));

   // R6: fill level stays within DEPTH
   assert_sp_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
      sp_q <= SP_W'(DEPTH));

   // R6: a push raises the level by exactly one
   assert_push_level_R6: assert property (@(posedge clk) disable iff (!rst_n)
      push |=> sp_q == $past(sp_q) + SP_W'(1));

endmodule

// File: rtl/simt_diverge_ctrl.sv
module simt_diverge_ctrl
   import simt_div_pkg::*;
#(
   parameter int unsigned LANES    = 32,
   parameter int unsigned PC_W     = 16,
   parameter int unsigned DEPTH    = 4,
   parameter logic [PC_W-1:0] RESET_PC = '0,
   localparam int unsigned CNT_W   = $clog2(LANES + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             br_valid,
   input  logic [LANES-1:0] br_pred,
   input  logic [PC_W-1:0]  br_target,
   input  logic [PC_W-1:0]  br_reconv,
   input  logic             path_done,
   output logic [PC_W-1:0]  cur_pc,
   output logic [LANES-1:0] act_mask,
   output logic [CNT_W-1:0] active_cnt,
   output logic             ovf_err
);

   generate
      if (LANES < 2) begin : g_bad_lanes
         $error("simt_diverge_ctrl: LANES must be at least 2");
      end
      if (PC_W < 2) begin : g_bad_pcw
         $error("simt_diverge_ctrl: PC_W must be at least 2");
      end
   endgenerate

   logic [LANES-1:0] tkn_lanes, not_lanes;
   br_kind_e         kind;
   logic             stk_empty, stk_full;
   logic [PC_W-1:0]  top_rc, top_ppc;
   logic [LANES-1:0] top_saved, top_pmask;
   logic             top_pv;
   logic             take_done, do_branch, push, pop, clr_pend;
   logic [PC_W-1:0]  fall_pc;

   // Only active lanes vote on the branch (R10).
   assign tkn_lanes = br_pred & act_mask;
   assign not_lanes = ~br_pred & act_mask;
   assign kind      = classify(|tkn_lanes, |not_lanes);
   assign fall_pc   = cur_pc + PC_W'(1);

   // path_done wins over a same-cycle branch (R9).
   assign take_done = path_done && !stk_empty;
   assign do_branch = br_valid && !path_done;
   assign push      = do_branch && (kind == BR_SPLIT) && !stk_full;
   assign clr_pend  = take_done && top_pv;
   assign pop       = take_done && !top_pv;

   simt_mask_stack #(
      .LANES (LANES),
      .PC_W  (PC_W),
      .DEPTH (DEPTH)
   ) u_stack (
      .clk        (clk),
      .rst_n      (rst_n),
      .push       (push),
      .push_rc    (br_reconv),
      .push_saved (act_mask),
      .push_pmask (not_lanes),
      .push_ppc   (fall_pc),
      .pop        (pop),
      .clr_pend   (clr_pend),
      .empty      (stk_empty),
      .full       (stk_full),
      .top_rc     (top_rc),
      .top_saved  (top_saved),
      .top_pmask  (top_pmask),
      .top_ppc    (top_ppc),
      .top_pv     (top_pv)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cur_pc   <= RESET_PC;
         act_mask <= '1;
         ovf_err  <= 1'b0;
      end else if (take_done) begin
         if (top_pv) begin
            cur_pc   <= top_ppc;
            act_mask <= top_pmask;
         end else begin
            cur_pc   <= top_rc;
            act_mask <= top_saved;
         end
      end else if (do_branch) begin
         unique case (kind)
            BR_UNI_TKN: cur_pc <= br_target;
            BR_UNI_NOT: cur_pc <= fall_pc;
            BR_SPLIT: begin
               if (stk_full) begin
                  ovf_err <= 1'b1;
               end else begin
                  cur_pc   <= br_target;
                  act_mask <= tkn_lanes;
               end
            end
            default: cur_pc <= cur_pc;
         endcase
      end
   end

   simt_popcount #(.WIDTH(LANES)) u_popcnt (
      .vec (act_mask),
      .cnt (active_cnt)
   );

   // R8: lane count agrees with the mask
   assert_cnt_match_R8: assert property (@(posedge clk) disable iff (!rst_n)
      active_cnt == CNT_W'($countones(act_mask)));

   // R6: mask is never empty
   assert_mask_nonzero_R6: assert property (@(posedge clk) disable iff (!rst_n)
      act_mask != '0);

   // R2: a uniform branch leaves the mask alone
   assert_uniform_keep_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (do_branch && kind != BR_SPLIT) |=> $stable(act_mask));

   // R3: a split narrows the mask to the taken lanes
   assert_split_mask_R3: assert property (@(posedge clk) disable iff (!rst_n)
      push |=> act_mask == $past(br_pred & act_mask));

   // R5: a final pop restores the saved mask
   assert_pop_restore_R5: assert property (@(posedge clk) disable iff (!rst_n)
      pop |=> act_mask == $past(top_saved));

   // R7: overflow flag is sticky
   assert_ovf_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
      ovf_err |=> ovf_err);

endmodule

// File: tb/simt_diverge_ctrl_tb.sv
module simt_diverge_ctrl_tb;

   localparam int L = 32;
   localparam int P = 16;
   localparam int D = 4;
   localparam int C = $clog2(L + 1);

   logic         clk = 1'b0;
   logic         rst_n;
   logic         br_valid;
   logic [L-1:0] br_pred;
   logic [P-1:0] br_target, br_reconv;
   logic         path_done;
   logic [P-1:0] cur_pc;
   logic [L-1:0] act_mask;
   logic [C-1:0] active_cnt;
   logic         ovf_err;

   int n_chk = 0;
   int n_fail = 0;

   // reference model state
   logic [P-1:0] m_pc;
   logic [L-1:0] m_mask;
   logic         m_err;
   logic [P-1:0] m_rc  [D];
   logic [L-1:0] m_sv  [D];
   logic [L-1:0] m_pm  [D];
   logic [P-1:0] m_ppc [D];
   logic         m_pv  [D];
   int           m_sp;

   always #5 clk = ~clk;

   simt_diverge_ctrl #(.LANES(L), .PC_W(P), .DEPTH(D)) u_dut (
      .clk        (clk),
      .rst_n      (rst_n),
      .br_valid   (br_valid),
      .br_pred    (br_pred),
      .br_target  (br_target),
      .br_reconv  (br_reconv),
      .path_done  (path_done),
      .cur_pc     (cur_pc),
      .act_mask   (act_mask),
      .active_cnt (active_cnt),
      .ovf_err    (ovf_err)
   );

   function automatic int ones(input logic [L-1:0] v);
      int s = 0;
      for (int i = 0; i < L; i++) s += int'(v[i]);
      return s;
   endfunction

   task automatic check(input string tag, input string what, input longint act, input longint exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
      end
   endtask

   task automatic check_all(input string tag);
      check(tag, "cur_pc", longint'(cur_pc), longint'(m_pc));
      check(tag, "act_mask", longint'(act_mask), longint'(m_mask));
      check(tag, "ovf_err", longint'(ovf_err), longint'(m_err));
      check("R8", "active_cnt", longint'(active_cnt), longint'(ones(m_mask)));
   endtask

   task automatic model_step(input logic bv, input logic [L-1:0] pr,
                             input logic [P-1:0] tg, input logic [P-1:0] rc, input logic pd);
      logic [L-1:0] tk;
      logic [L-1:0] nt;
      int ix;
      tk = pr & m_mask;
      nt = ~pr & m_mask;
      if (pd) begin
         if (m_sp > 0) begin
            ix = m_sp - 1;
            if (m_pv[ix]) begin
               m_pc = m_ppc[ix];
               m_mask = m_pm[ix];
               m_pv[ix] = 1'b0;
            end else begin
               m_pc = m_rc[ix];
               m_mask = m_sv[ix];
               m_sp--;
            end
         end
      end else if (bv) begin
         if (tk == '0) m_pc = m_pc + P'(1);
         else if (nt == '0) m_pc = tg;
         else if (m_sp == D) m_err = 1'b1;
         else begin
            m_rc[m_sp] = rc;
            m_sv[m_sp] = m_mask;
            m_pm[m_sp] = nt;
            m_ppc[m_sp] = m_pc + P'(1);
            m_pv[m_sp] = 1'b1;
            m_sp++;
            m_pc = tg;
            m_mask = tk;
         end
      end
   endtask

   task automatic step(input logic bv, input logic [L-1:0] pr, input logic [P-1:0] tg,
                       input logic [P-1:0] rc, input logic pd, input string tag);
      @(negedge clk);
      br_valid = bv; br_pred = pr; br_target = tg; br_reconv = rc; path_done = pd;
      model_step(bv, pr, tg, rc, pd);
      @(posedge clk);
      #1;
      check_all(tag);
      br_valid = 1'b0; path_done = 1'b0;
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      br_valid = 1'b0; path_done = 1'b0; br_pred = '0; br_target = '0; br_reconv = '0;
      m_pc = '0; m_mask = '1; m_err = 1'b0; m_sp = 0;
      for (int i = 0; i < D; i++) m_pv[i] = 1'b0;
      repeat (2) @(posedge clk);
      #1;
      rst_n = 1'b1;
      check_all("R1");
   endtask

   task automatic finish_run();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      void'($urandom(32'd20240611));
      do_reset();

      // R2 uniform outcomes
      step(1'b1, '1, 16'h0040, 16'h0100, 1'b0, "R2");
      step(1'b1, '0, 16'h0200, 16'h0100, 1'b0, "R2");

      // R3/R4/R5 single divergence, R10 inside the second path
      step(1'b1, 32'h0000_FFFF, 16'h0300, 16'h0380, 1'b0, "R3");
      check("R3", "active_cnt", longint'(active_cnt), 16);
      step(1'b0, '0, '0, '0, 1'b1, "R4");
      check("R4", "act_mask", longint'(act_mask), 32'hFFFF_0000);
      step(1'b1, 32'h0000_FFFF, 16'h0500, 16'h0600, 1'b0, "R10");
      step(1'b0, '0, '0, '0, 1'b1, "R5");
      check("R5", "act_mask", longint'(act_mask), 32'hFFFF_FFFF);

      // R9 empty strobe, then collision priority
      step(1'b0, '0, '0, '0, 1'b1, "R9");
      step(1'b1, 32'h00FF_00FF, 16'h0700, 16'h0780, 1'b0, "R3");
      step(1'b1, 32'h0000_00FF, 16'h0710, 16'h0720, 1'b1, "R9");
      step(1'b0, '0, '0, '0, 1'b1, "R5");

      // R6/R7 nest to full depth, overflow, unwind
      step(1'b1, 32'h0000_FFFF, 16'h1000, 16'h1F00, 1'b0, "R6");
      step(1'b1, 32'h0000_00FF, 16'h1100, 16'h1E00, 1'b0, "R6");
      step(1'b1, 32'h0000_000F, 16'h1200, 16'h1D00, 1'b0, "R6");
      step(1'b1, 32'h0000_0003, 16'h1300, 16'h1C00, 1'b0, "R6");
      step(1'b1, 32'h0000_0001, 16'h1400, 16'h1B00, 1'b0, "R7");
      check("R7", "ovf_err", longint'(ovf_err), 1);
      for (int k = 0; k < 2 * D; k++) step(1'b0, '0, '0, '0, 1'b1, "R6");
      check("R6", "act_mask", longint'(act_mask), 32'hFFFF_FFFF);
      step(1'b0, '0, '0, '0, 1'b1, "R9");
      step(1'b1, 32'h0F0F_0F0F, 16'h2000, 16'h2100, 1'b0, "R7");

      // random traffic against the model
      do_reset();
      for (int n = 0; n < 4000; n++) begin
         int sel;
         logic [L-1:0] pr;
         sel = int'($urandom_range(0, 9));
         case (int'($urandom_range(0, 3)))
            0: pr = '1;
            1: pr = '0;
            2: pr = m_mask ^ L'($urandom);
            default: pr = L'($urandom);
         endcase
         if (n == 2000) do_reset();
         if (sel < 3)      step(1'b0, pr, P'($urandom), P'($urandom), 1'b1, "R5");
         else if (sel < 8) step(1'b1, pr, P'($urandom), P'($urandom), 1'b0, "R3");
         else if (sel < 9) step(1'b1, pr, P'($urandom), P'($urandom), 1'b1, "R9");
         else              step(1'b0, pr, P'($urandom), P'($urandom), 1'b0, "R2");
      end

      finish_run();
   end

endmodule